// File: doc/BRIEF.md
# Sleep Wake-Up Interrupt Sequencer

This block decides when a processor core is halted for a low-power sleep and how the core comes back. It runs on a four-clock instruction cycle, with phases Q1 to Q4 produced by a free-running internal phase counter. All state changes take effect only when a cycle ends. The decoder signals a sleep instruction with a strobe. If no interrupt is already pending, the block halts the core from the next instruction cycle. The instruction after the sleep is already fetched and waits in the pipeline.

A rising edge on the external interrupt pin sets a sticky interrupt flag, which wakes a sleeping core. The oscillator mode is captured when sleep is entered. Crystal-type modes add a start-up wait of 1024 clocks before the core runs again. External-clock and RC modes resume at the next cycle boundary. The first cycle after wake-up always executes the prefetched instruction. The interrupt enable, captured at wake-up, then chooses the next step. When it is set, one dummy cycle follows and carries a program-counter load request to the vector 0x0004. When it is clear, execution simply continues in line.

Top module: `swk_sleep_seq`

## Requirements
- R1: `phase_o` counts 0,1,2,3,0,… one step per clock from 0 after reset, and `core_halt_o`, `dummy_o` and `pc_load_o` change only on the clock edge at which `phase_o` was 3.
- R2: A `sleep_exec_i` seen at a cycle boundary (phase 3) while the core runs and the flag is clear raises `core_halt_o` on that edge. `osc_mode_i` is captured on that edge, and later changes to it have no effect on the sleep in progress.
- R3: A rising edge on `ext_int_i` sets `int_flag_o` on the next clock. The flag stays set until `int_clr_i` is high at a clock edge. A rising edge in the same cycle as a clear wins.
- R4: A sleep strobe at a boundary while `int_flag_o` is already 1 leaves `core_halt_o` low.
- R5: While halted without a flag, the core stays halted. With the flag set at a boundary during sleep, the wake-up sequence starts.
- R6: Modes 3'b000, 3'b001 and 3'b010 are the crystal modes. After the flag sets in phase p (as seen on `phase_o` after the setting edge), `core_halt_o` falls exactly 4-p+1024 clocks later.
- R7: For any other mode (3'b011 external clock, 3'b1xx RC), `core_halt_o` falls exactly 4-p clocks after the flag sets.
- R8: The first instruction cycle after `core_halt_o` falls has `dummy_o`=0 and `pc_load_o`=0, which lets the prefetched instruction execute.
- R9: If `gie_i` was 1 at the wake boundary, the next cycle has `dummy_o`=1, `pc_load_o`=1 and `pc_vec_o`=0x0004 for its four clocks. The block then returns to run with both low.
- R10: If `gie_i` was 0 at the wake boundary, no dummy cycle and no PC load occur and the core keeps running.
- R11: While `rst` is high, all outputs are 0 (run state, flag clear, phase 0).
- R12: A sleep strobe during the post-wake execute cycle is ignored and the core is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec_i | input | 1 | Sleep instruction executing, sampled at phase 3 |
| ext_int_i | input | 1 | External interrupt pin, rising-edge sensitive |
| int_clr_i | input | 1 | Software clear of the interrupt flag |
| gie_i | input | 1 | Global interrupt enable |
| osc_mode_i | input | 3 | Oscillator mode: 0-2 crystal, 3 external clock, 4-7 RC |
| core_halt_o | output | 1 | Core halted (sleep or start-up wait) |
| int_flag_o | output | 1 | Sticky external interrupt flag |
| pc_load_o | output | 1 | Program counter redirect request |
| pc_vec_o | output | PC_W | Redirect target, 0x0004 while loading, else 0 |
| dummy_o | output | 1 | Dummy cycle insert |
| phase_o | output | 2 | Current clock phase within the instruction cycle |

## Verification
The hardest situation to reach is a wake-up whose interrupt edge falls in each of the four phases while the oscillator mode and the enable bit change during sleep. It has to be tested once with the 1024-clock start-up wait and once without it. The stimulus aligns to `phase_o` for directed sleeps, places the pin edge at a chosen phase and counts clocks until the halt drops. Random stretches then mix sleep strobes, pin edges, flag clears and mode changes. Some of those sleeps are refused because the flag is already pending.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OST    = 3'd2,
    ST_RESUME = 3'd3,
    ST_DUMMY  = 3'd4
  } swk_state_e;

  localparam logic [2:0] OSC_LP = 3'd0;
  localparam logic [2:0] OSC_XT = 3'd1;
  localparam logic [2:0] OSC_HS = 3'd2;
  localparam logic [2:0] OSC_EC = 3'd3;

  // crystal-type modes need the start-up wait
  function automatic logic needs_ost(input logic [2:0] mode);
    return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
  endfunction

endpackage

// File: rtl/swk_phase_gen.sv
module swk_phase_gen #(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase_o,
  output logic            cyc_end_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase_o <= '0;
    else if (phase_o == LAST) phase_o <= '0;
    else                    phase_o <= phase_o + 1'b1;
  end

  assign cyc_end_o = (phase_o == LAST);
endmodule

// File: rtl/swk_int_flag.sv
module swk_int_flag (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (pin_i && !pin_q) flag_o <= 1'b1;
      else if (clr_i)      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/swk_ost_counter.sv
module swk_ost_counter #(
  parameter int TERM = 1024,
  localparam int CW = $clog2(TERM)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt <= '0;
    else if (en_i && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LAST);
endmodule

// File: rtl/swk_sleep_seq.sv
module swk_sleep_seq
  import swk_pkg::*;
#(
  parameter int PHASES   = 4,
  parameter int OST_CLKS = 1024,
  parameter int PC_W     = 13,
  parameter int VEC_ADDR = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_exec_i,
  input  logic            ext_int_i,
  input  logic            int_clr_i,
  input  logic            gie_i,
  input  logic [2:0]      osc_mode_i,
  output logic            core_halt_o,
  output logic            int_flag_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_vec_o,
  output logic            dummy_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  swk_state_e st, st_nxt;
  logic cyc_end, ost_done, long_q, gie_q;
  logic enter_sleep, wake;

  swk_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .phase_o(phase_o), .cyc_end_o(cyc_end)
  );

  swk_int_flag u_flag (
    .clk(clk), .rst(rst), .pin_i(ext_int_i), .clr_i(int_clr_i),
    .flag_o(int_flag_o)
  );

  swk_ost_counter #(.TERM(OST_CLKS)) u_ost (
    .clk(clk), .rst(rst), .clr_i(enter_sleep), .en_i(st == ST_OST),
    .done_o(ost_done)
  );

  assign enter_sleep = cyc_end && (st == ST_RUN) && sleep_exec_i && !int_flag_o;
  assign wake        = cyc_end && (st == ST_SLEEP) && int_flag_o;

  always_comb begin
    st_nxt = st;
    if (cyc_end) begin
      unique case (st)
        ST_RUN:    if (sleep_exec_i && !int_flag_o) st_nxt = ST_SLEEP;
        ST_SLEEP:  if (int_flag_o) st_nxt = long_q ? ST_OST : ST_RESUME;
        ST_OST:    if (ost_done) st_nxt = ST_RESUME;
        ST_RESUME: st_nxt = gie_q ? ST_DUMMY : ST_RUN;
        ST_DUMMY:  st_nxt = ST_RUN;
        default:   st_nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      long_q      <= 1'b0;
      gie_q       <= 1'b0;
      core_halt_o <= 1'b0;
      pc_load_o   <= 1'b0;
      dummy_o     <= 1'b0;
      pc_vec_o    <= '0;
    end else begin
      st          <= st_nxt;
      core_halt_o <= (st_nxt == ST_SLEEP) || (st_nxt == ST_OST);
      pc_load_o   <= (st_nxt == ST_DUMMY);
      dummy_o     <= (st_nxt == ST_DUMMY);
      pc_vec_o    <= (st_nxt == ST_DUMMY) ? VEC : '0;
      if (enter_sleep) long_q <= needs_ost(osc_mode_i);
      if (wake)        gie_q  <= gie_i;
    end
  end
endmodule

// File: rtl/swk_sleep_seq_chk.sv
module swk_sleep_seq_chk #(
  parameter int PHASES   = 4,
  parameter int PC_W     = 13,
  parameter int VEC_ADDR = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input logic            clk,
  input logic            rst,
  input logic            sleep_exec_i,
  input logic            ext_int_i,
  input logic            int_clr_i,
  input logic            core_halt_o,
  input logic            int_flag_o,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_vec_o,
  input logic            dummy_o,
  input logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  // R1
  halt_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (core_halt_o != $past(core_halt_o)) |-> ($past(phase_o) == LAST));

  // R1
  dummy_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (dummy_o != $past(dummy_o)) |-> ($past(phase_o) == LAST));

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_int_i && !$past(ext_int_i)) |=> int_flag_o);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int_flag_o && !int_clr_i) |=> int_flag_o);

  // R4
  no_sleep_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == LAST && sleep_exec_i && int_flag_o && !core_halt_o) |=> !core_halt_o);

  // R8
  resume_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_halt_o) |-> (!dummy_o && !pc_load_o));

  // R9
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> (dummy_o && !core_halt_o && pc_vec_o == PC_W'(VEC_ADDR)));
endmodule

bind swk_sleep_seq swk_sleep_seq_chk #(
  .PHASES(PHASES), .PC_W(PC_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec_i), .ext_int_i(ext_int_i),
  .int_clr_i(int_clr_i), .core_halt_o(core_halt_o), .int_flag_o(int_flag_o),
  .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o), .dummy_o(dummy_o),
  .phase_o(phase_o)
);

// File: tb/swk_sleep_seq_bench.sv
`timescale 1ns/1ps
module swk_sleep_seq_bench;
  localparam int PC_W = 13;
  localparam int OSTC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_exec_i = 1'b0, ext_int_i = 1'b0, int_clr_i = 1'b0, gie_i = 1'b0;
  logic [2:0] osc_mode_i = 3'd3;
  logic core_halt_o, int_flag_o, pc_load_o, dummy_o;
  logic [PC_W-1:0] pc_vec_o;
  logic [1:0] phase_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  swk_sleep_seq u_swk_sleep_seq (
    .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec_i), .ext_int_i(ext_int_i),
    .int_clr_i(int_clr_i), .gie_i(gie_i), .osc_mode_i(osc_mode_i),
    .core_halt_o(core_halt_o), .int_flag_o(int_flag_o), .pc_load_o(pc_load_o),
    .pc_vec_o(pc_vec_o), .dummy_o(dummy_o), .phase_o(phase_o)
  );

  // reference model, states: 0 run 1 sleep 2 wait 3 execute 4 dummy
  int m_ph, m_st, m_cnt;
  bit m_prev, m_flag, m_long, m_gie;

  function automatic bit is_crystal(input logic [2:0] m);
    return m <= 3'd2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit bnd, rise;
    int nst;
    bnd  = (m_ph == 3);
    rise = ext_int_i && !m_prev;
    nst  = m_st;
    if (bnd) begin
      case (m_st)
        0: if (sleep_exec_i && !m_flag) begin
             nst = 1; m_long = is_crystal(osc_mode_i); m_cnt = 0;
           end
        1: if (m_flag) begin nst = m_long ? 2 : 3; m_gie = gie_i; end
        2: if (m_cnt == OSTC - 1) nst = 3;
        3: nst = m_gie ? 4 : 0;
        default: nst = 0;
      endcase
    end
    if (m_st == 2 && m_cnt != OSTC - 1) m_cnt++;
    if (rise) m_flag = 1'b1;
    else if (int_clr_i) m_flag = 1'b0;
    m_prev = ext_int_i;
    m_ph   = (m_ph + 1) % 4;
    m_st   = nst;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R1", phase_o, m_ph, "phase");
    chk("R2", core_halt_o, (m_st == 1 || m_st == 2), "halt");
    chk("R3", int_flag_o, m_flag, "flag");
    chk("R9", dummy_o, (m_st == 4), "dummy");
    chk("R9", pc_load_o, (m_st == 4), "pc_load");
    chk("R9", pc_vec_o, (m_st == 4) ? 4 : 0, "pc_vec");
  endtask

  task automatic to_phase(input int p);
    while (phase_o != 2'(p)) step();
  endtask

  task automatic clear_flag();
    int_clr_i = 1'b1; step(); int_clr_i = 1'b0;
  endtask

  task automatic wake_test(input logic [2:0] mode, input bit gie, input int edge_ph);
    int n, p, exp;
    clear_flag();
    to_phase(3);
    osc_mode_i = mode; sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
    chk("R2", core_halt_o, 1, "halt after sleep strobe");
    osc_mode_i = is_crystal(mode) ? 3'd5 : 3'd1;   // must be ignored
    gie_i = gie;
    repeat (9) step();
    chk("R5", core_halt_o, 1, "stays halted without flag");
    to_phase(edge_ph);
    ext_int_i = 1'b1; step(); ext_int_i = 1'b0;
    chk("R3", int_flag_o, 1, "flag after pin edge");
    p = phase_o;
    exp = 4 - p + (is_crystal(mode) ? OSTC : 0);
    n = 0;
    while (core_halt_o && n < 3000) begin step(); n++; end
    chk(is_crystal(mode) ? "R6" : "R7", n, exp, "clocks flag to resume");
    chk("R8", dummy_o + pc_load_o, 0, "execute cycle has no dummy");
    chk("R3", int_flag_o, 1, "flag held after wake");
    clear_flag(); step(); step();
    chk("R1", phase_o, 3, "end of execute cycle");
    sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
    chk("R12", core_halt_o, 0, "sleep in execute cycle ignored");
    if (gie) begin
      chk("R9", dummy_o, 1, "dummy cycle");
      chk("R9", pc_load_o, 1, "pc load");
      chk("R9", pc_vec_o, 4, "vector");
    end else begin
      chk("R10", dummy_o + pc_load_o, 0, "in-line continuation");
    end
    repeat (4) step();
    chk(gie ? "R9" : "R10", dummy_o + pc_load_o + core_halt_o, 0, "back to run");
  endtask

  initial begin
    #3_600_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ph = 0; m_st = 0; m_cnt = 0;
    m_prev = 0; m_flag = 0; m_long = 0; m_gie = 0;
    repeat (3) @(negedge clk);
    chk("R11", core_halt_o + int_flag_o + pc_load_o + dummy_o, 0, "outputs in reset");
    chk("R11", phase_o, 0, "phase in reset");
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R1", phase_o, (i + 1) % 4, "phase count");
    end
    // R3: set wins over clear
    ext_int_i = 1'b1; int_clr_i = 1'b1; step();
    ext_int_i = 1'b0; int_clr_i = 1'b0;
    chk("R3", int_flag_o, 1, "edge beats clear");
    repeat (5) step();
    chk("R3", int_flag_o, 1, "flag sticky");
    // R4: pending flag refuses sleep
    to_phase(3);
    sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
    chk("R4", core_halt_o, 0, "sleep refused with flag");
    repeat (4) step();
    chk("R4", core_halt_o, 0, "still running");
    // directed wake-ups over phases, modes and enable
    for (int k = 0; k < 8; k++) begin
      logic [2:0] md;
      md = (k % 2 == 0) ? 3'(k % 3) : 3'(3 + (k % 5));
      wake_test(md, k[1], k % 4);
    end
    // random stretch
    clear_flag();
    for (int i = 0; i < 30000; i++) begin
      sleep_exec_i = ($urandom % 6) == 0;
      if (($urandom % 30) == 0) ext_int_i = ~ext_int_i;
      int_clr_i  = ($urandom % 20) == 0;
      gie_i      = $urandom % 2;
      osc_mode_i = 3'($urandom % 8);
      if (m_st == 2 && ($urandom % 4) != 0) osc_mode_i = 3'd7;
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule